// File: doc/BRIEF.md
# Halfword-Swapping Network DMA Address Front End

This block sits between a 16-bit network peripheral and a memory request port. The peripheral asks for a transfer by giving a low address, a byte length, a direction and a swap flag. The block builds the full memory address by OR-ing the low address with a high-address value that is programmed elsewhere. It then issues one or more memory commands and streams 16-bit data beats between the peripheral and memory.

In pass-through mode the address, the length and the data are used exactly as given. In swap mode the block forces halfword alignment and exchanges the two bytes of every 16-bit lane, on both the write path and the read path. In swap mode, memory writes are cut into bounded chunks. Each chunk has its own command and its own last-beat marker.

A request is accepted only while the block is idle. The block reports `busy` until the last beat of the last chunk, and then pulses `done` for one cycle.

Top module: `dma_hsw_front`

## Requirements
- R1: The memory command address of the first command is the request low address OR-ed with `hi_addr`, both sampled in the cycle the request is accepted.
- R2: In pass-through mode (`req_swap`=0), the block issues exactly one command whose length equals the request length, odd lengths included. Data crosses in both directions with no byte change.
- R3: In swap mode (`req_swap`=1), bit 0 of the command address and bit 0 of the total length are cleared before any command is issued.
- R4: In swap mode, each memory write beat equals the peripheral write beat with its byte [15:8] and byte [7:0] exchanged.
- R5: In swap mode, each read beat handed to the peripheral equals the memory read beat with its two bytes exchanged.
- R6: Swapped writes (`req_to_mem`=1, `req_swap`=1) are issued as commands of at most CHUNK_BYTES (64) bytes each. Each command address is the previous address plus the previous length, and the lengths add up to the aligned total.
- R7: Reads are never split: a read in either mode is one command of the whole (aligned) length.
- R8: A command of N bytes carries ceil(N/2) data beats. On the write path `mem_wlast` is high on the last beat only.
- R9: `busy` is high from the cycle after acceptance until the final beat is transferred, and `req_ready` is low while `busy` is high. A request presented while busy is never accepted and produces no command.
- R10: A request whose effective length is zero (length 0, or length 1 in swap mode) issues no command. It keeps `busy` low and pulses `done` in the cycle after acceptance.
- R11: After reset, `busy`, `done`, `mem_cmd_valid` and `mem_wvalid` are low and `req_ready` is high.
- R12: While `mem_cmd_valid` is high and `mem_cmd_ready` is low, the command stays valid with an unchanged address, length and direction.
- R13: `done` pulses for exactly one cycle, in the cycle after the final beat is transferred, and `busy` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hi_addr | input | ADDR_W | High-address value OR-ed into every request address |
| req_valid | input | 1 | Peripheral request present |
| req_ready | output | 1 | Request can be accepted (block idle) |
| req_addr | input | ADDR_W | Low address of the request |
| req_len | input | LEN_W | Request length in bytes |
| req_to_mem | input | 1 | 1: peripheral to memory (write), 0: memory to peripheral (read) |
| req_swap | input | 1 | 1: swap mode, 0: pass-through |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| per_wvalid | input | 1 | Peripheral write beat valid |
| per_wready | output | 1 | Peripheral write beat taken |
| per_wdata | input | DATA_W | Peripheral write beat |
| per_rvalid | output | 1 | Read beat valid toward peripheral |
| per_rready | input | 1 | Peripheral can take a read beat |
| per_rdata | output | DATA_W | Read beat toward peripheral |
| mem_cmd_valid | output | 1 | Memory command valid |
| mem_cmd_ready | input | 1 | Memory command accepted |
| mem_cmd_addr | output | ADDR_W | Command byte address |
| mem_cmd_len | output | LEN_W | Command byte length |
| mem_cmd_write | output | 1 | Command direction, 1 = write |
| mem_wvalid | output | 1 | Memory write beat valid |
| mem_wready | input | 1 | Memory write beat taken |
| mem_wdata | output | DATA_W | Memory write beat |
| mem_wlast | output | 1 | Last write beat of the current command |
| mem_rvalid | input | 1 | Memory read beat valid |
| mem_rready | output | 1 | Read beat taken |
| mem_rdata | input | DATA_W | Memory read beat |

## Verification
The state that matters here is the running address, the remaining length and the beat count. A wrong remaining length or a wrong address step shows up at the very next command of a chunked write: its `mem_cmd_addr` or `mem_cmd_len` no longer matches the expected step. A wrong beat count shows up within one chunk, either as `mem_wlast` on the wrong beat or as the final `done` pulse arriving early or late. A swap flag latched wrongly shows on the first data beat as byte lanes that are or are not exchanged, and on the first command as an odd address or length.

// File: rtl/dma_hsw_pkg.sv
// Shared types and helpers for the halfword-swapping DMA front end.
package dma_hsw_pkg;

    // Sequencer states: idle, presenting a command, moving data beats.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CMD  = 2'd1,
        ST_DATA = 2'd2
    } seq_state_t;

    // Exchange the two bytes of one 16-bit halfword.
    function automatic logic [15:0] swap_half(input logic [15:0] h);
        return {h[7:0], h[15:8]};
    endfunction

endpackage

// File: rtl/dma_hsw_addr_form.sv
// Forms the effective start address and total length of a request.
// The low address is OR-ed with the high-address value. In swap mode,
// bit 0 of both the address and the length is cleared.
// Assumes: purely combinational, sampled by the caller on acceptance.
module dma_hsw_addr_form #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic [ADDR_W-1:0] lo_addr,
    input  logic [ADDR_W-1:0] hi_addr,
    input  logic [LEN_W-1:0]  len_in,
    input  logic              swap_en,
    output logic [ADDR_W-1:0] eff_addr,
    output logic [LEN_W-1:0]  eff_len
);

    // Combine address halves and apply halfword alignment in swap mode.
    always_comb begin
        eff_addr = lo_addr | hi_addr;
        eff_len  = len_in;
        if (swap_en) begin
            eff_addr[0] = 1'b0;
            eff_len[0]  = 1'b0;
        end
    end

endmodule

// File: rtl/dma_hsw_chunk_sel.sv
// Picks the byte length of the next memory command and its beat count.
// When limiting is enabled, a command never exceeds CHUNK_BYTES.
// Assumes: BEAT_BYTES is a power of two.
module dma_hsw_chunk_sel #(
    parameter int LEN_W       = 16,
    parameter int CHUNK_BYTES = 64,
    parameter int BEAT_BYTES  = 2
) (
    input  logic [LEN_W-1:0] remaining,
    input  logic             limit_en,
    output logic [LEN_W-1:0] chunk_len,
    output logic [LEN_W-1:0] chunk_beats
);

    localparam logic [LEN_W-1:0] CHUNK_L = LEN_W'(CHUNK_BYTES);
    localparam int               BEAT_SH = $clog2(BEAT_BYTES);
    localparam logic [LEN_W:0]   ROUND_UP = (LEN_W+1)'(BEAT_BYTES - 1);

    logic [LEN_W:0] rounded;

    // Clamp the chunk when limiting and round the byte count up to beats.
    always_comb begin
        chunk_len   = (limit_en && (remaining > CHUNK_L)) ? CHUNK_L : remaining;
        rounded     = {1'b0, chunk_len} + ROUND_UP;
        chunk_beats = LEN_W'(rounded >> BEAT_SH);
    end

endmodule

// File: rtl/dma_hsw_lane_swap.sv
// Optionally exchanges the bytes within every 16-bit lane of a beat.
// Assumes: DATA_W is a multiple of 16.
module dma_hsw_lane_swap #(
    parameter int DATA_W = 16
) (
    input  logic              swap_en,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    import dma_hsw_pkg::*;

    localparam int LANES = DATA_W / 16;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Per-lane byte exchange or pass-through.
        assign dout[g*16 +: 16] = swap_en ? swap_half(din[g*16 +: 16])
                                          : din[g*16 +: 16];
    end

endmodule

// File: rtl/dma_hsw_front.sv
// Network DMA address and data front end with halfword swap.
// Accepts one request while idle, forms the address, and issues commands.
// Swapped writes are split into chunks of at most CHUNK_BYTES. Each command
// is followed by its data beats; the byte lanes are swapped in swap mode.
// Assumes: one outstanding command; data beats follow their command in order.
module dma_hsw_front #(
    parameter int ADDR_W      = 32,
    parameter int LEN_W       = 16,
    parameter int DATA_W      = 16,
    parameter int CHUNK_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] hi_addr,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_to_mem,
    input  logic              req_swap,
    output logic              busy,
    output logic              done,
    input  logic              per_wvalid,
    output logic              per_wready,
    input  logic [DATA_W-1:0] per_wdata,
    output logic              per_rvalid,
    input  logic              per_rready,
    output logic [DATA_W-1:0] per_rdata,
    output logic              mem_cmd_valid,
    input  logic              mem_cmd_ready,
    output logic [ADDR_W-1:0] mem_cmd_addr,
    output logic [LEN_W-1:0]  mem_cmd_len,
    output logic              mem_cmd_write,
    output logic              mem_wvalid,
    input  logic              mem_wready,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_wlast,
    input  logic              mem_rvalid,
    output logic              mem_rready,
    input  logic [DATA_W-1:0] mem_rdata
);
    import dma_hsw_pkg::*;

    localparam int               BEAT_BYTES = DATA_W / 8;
    localparam logic [LEN_W-1:0] ONE_BEAT   = LEN_W'(1);

    seq_state_t        state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  rem_q;
    logic [LEN_W-1:0]  chunk_q;
    logic [LEN_W-1:0]  beats_q;
    logic              wr_q;
    logic              swap_q;
    logic              done_q;

    logic [ADDR_W-1:0] form_addr;
    logic [LEN_W-1:0]  form_len;
    logic [LEN_W-1:0]  chunk_c;
    logic [LEN_W-1:0]  beats_c;
    logic              accept;
    logic              in_data;
    logic              beat_fire;
    logic              last_beat;

    dma_hsw_addr_form #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W)
    ) u_addr_form (
        .lo_addr  (req_addr),
        .hi_addr  (hi_addr),
        .len_in   (req_len),
        .swap_en  (req_swap),
        .eff_addr (form_addr),
        .eff_len  (form_len)
    );

    dma_hsw_chunk_sel #(
        .LEN_W       (LEN_W),
        .CHUNK_BYTES (CHUNK_BYTES),
        .BEAT_BYTES  (BEAT_BYTES)
    ) u_chunk_sel (
        .remaining   (rem_q),
        .limit_en    (wr_q & swap_q),
        .chunk_len   (chunk_c),
        .chunk_beats (beats_c)
    );

    dma_hsw_lane_swap #(
        .DATA_W (DATA_W)
    ) u_wr_swap (
        .swap_en (swap_q),
        .din     (per_wdata),
        .dout    (mem_wdata)
    );

    dma_hsw_lane_swap #(
        .DATA_W (DATA_W)
    ) u_rd_swap (
        .swap_en (swap_q),
        .din     (mem_rdata),
        .dout    (per_rdata)
    );

    // Handshake decode for request acceptance and data beats.
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        accept    = req_valid && req_ready;
        in_data   = (state_q == ST_DATA);
        beat_fire = in_data && (wr_q ? (per_wvalid && mem_wready)
                                     : (mem_rvalid && per_rready));
        last_beat = beat_fire && (beats_q == ONE_BEAT);
    end

    // Port-facing outputs derived from the sequencer state.
    always_comb begin
        busy          = (state_q != ST_IDLE);
        done          = done_q;
        mem_cmd_valid = (state_q == ST_CMD);
        mem_cmd_addr  = addr_q;
        mem_cmd_len   = chunk_c;
        mem_cmd_write = wr_q;
        mem_wvalid    = in_data && wr_q && per_wvalid;
        per_wready    = in_data && wr_q && mem_wready;
        mem_wlast     = in_data && wr_q && (beats_q == ONE_BEAT);
        mem_rready    = in_data && !wr_q && per_rready;
        per_rvalid    = in_data && !wr_q && mem_rvalid;
    end

    // Sequencer: accept, issue commands, count beats, advance the address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            rem_q   <= '0;
            chunk_q <= '0;
            beats_q <= '0;
            wr_q    <= 1'b0;
            swap_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        addr_q <= form_addr;
                        rem_q  <= form_len;
                        wr_q   <= req_to_mem;
                        swap_q <= req_swap;
                        if (form_len == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            state_q <= ST_CMD;
                        end
                    end
                end
                ST_CMD: begin
                    if (mem_cmd_ready) begin
                        chunk_q <= chunk_c;
                        beats_q <= beats_c;
                        state_q <= ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (beat_fire) begin
                        beats_q <= beats_q - ONE_BEAT;
                    end
                    if (last_beat) begin
                        rem_q  <= rem_q - chunk_q;
                        addr_q <= addr_q + ADDR_W'(chunk_q);
                        if (rem_q == chunk_q) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            state_q <= ST_CMD;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dma_hsw_front_chk.sv
// Protocol checker for dma_hsw_front, attached with bind below.
// Watches the ports plus the latched mode flags of the sequencer.
module dma_hsw_front_chk #(
    parameter int ADDR_W      = 32,
    parameter int LEN_W       = 16,
    parameter int CHUNK_BYTES = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              busy,
    input logic              done,
    input logic              mem_cmd_valid,
    input logic              mem_cmd_ready,
    input logic [ADDR_W-1:0] mem_cmd_addr,
    input logic [LEN_W-1:0]  mem_cmd_len,
    input logic              mem_cmd_write,
    input logic              mem_wvalid,
    input logic              swap_q,
    input logic              wr_q
);

    localparam logic [LEN_W-1:0] CHUNK_L = LEN_W'(CHUNK_BYTES);

    AST_REQ_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !req_ready);                                             // R9

    AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cmd_valid && !mem_cmd_ready) |=>
            (mem_cmd_valid && $stable(mem_cmd_addr) && $stable(mem_cmd_len)
             && $stable(mem_cmd_write)));                                 // R12

    AST_SWAP_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cmd_valid && swap_q) |-> (!mem_cmd_addr[0] && !mem_cmd_len[0])); // R3

    AST_CHUNK_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cmd_valid && swap_q && wr_q) |->
            ((mem_cmd_len <= CHUNK_L) && (mem_cmd_len != '0)));           // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_cmd_valid && !mem_wvalid));                       // R10

    AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);                                            // R13

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                  // R13

endmodule

bind dma_hsw_front dma_hsw_front_chk #(
    .ADDR_W      (ADDR_W),
    .LEN_W       (LEN_W),
    .CHUNK_BYTES (CHUNK_BYTES)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_ready     (req_ready),
    .busy          (busy),
    .done          (done),
    .mem_cmd_valid (mem_cmd_valid),
    .mem_cmd_ready (mem_cmd_ready),
    .mem_cmd_addr  (mem_cmd_addr),
    .mem_cmd_len   (mem_cmd_len),
    .mem_cmd_write (mem_cmd_write),
    .mem_wvalid    (mem_wvalid),
    .swap_q        (swap_q),
    .wr_q          (wr_q)
);

// File: tb/dma_hsw_front_tb.sv
// Directed bench for dma_hsw_front: one task per scenario.
module dma_hsw_front_tb;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 32;
    localparam int LEN_W  = 16;
    localparam int DATA_W = 16;
    localparam int CHUNK  = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] hi_addr = '0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [LEN_W-1:0]  req_len = '0;
    logic              req_to_mem = 1'b0;
    logic              req_swap = 1'b0;
    logic              busy, done;
    logic              per_wvalid = 1'b0;
    logic              per_wready;
    logic [DATA_W-1:0] per_wdata = '0;
    logic              per_rvalid;
    logic              per_rready = 1'b0;
    logic [DATA_W-1:0] per_rdata;
    logic              mem_cmd_valid;
    logic              mem_cmd_ready = 1'b0;
    logic [ADDR_W-1:0] mem_cmd_addr;
    logic [LEN_W-1:0]  mem_cmd_len;
    logic              mem_cmd_write;
    logic              mem_wvalid;
    logic              mem_wready = 1'b0;
    logic [DATA_W-1:0] mem_wdata;
    logic              mem_wlast;
    logic              mem_rvalid = 1'b0;
    logic              mem_rready;
    logic [DATA_W-1:0] mem_rdata = '0;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_hsw_front #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W), .CHUNK_BYTES(CHUNK)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .hi_addr(hi_addr),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_len(req_len), .req_to_mem(req_to_mem), .req_swap(req_swap),
        .busy(busy), .done(done),
        .per_wvalid(per_wvalid), .per_wready(per_wready), .per_wdata(per_wdata),
        .per_rvalid(per_rvalid), .per_rready(per_rready), .per_rdata(per_rdata),
        .mem_cmd_valid(mem_cmd_valid), .mem_cmd_ready(mem_cmd_ready),
        .mem_cmd_addr(mem_cmd_addr), .mem_cmd_len(mem_cmd_len),
        .mem_cmd_write(mem_cmd_write),
        .mem_wvalid(mem_wvalid), .mem_wready(mem_wready), .mem_wdata(mem_wdata),
        .mem_wlast(mem_wlast),
        .mem_rvalid(mem_rvalid), .mem_rready(mem_rready), .mem_rdata(mem_rdata)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] bswap(input logic [15:0] h);
        return {h[7:0], h[15:8]};
    endfunction

    // Generic transfer driver with an independent model of the expected commands.
    task automatic run_xfer(input logic [31:0] lo, input logic [15:0] len,
                            input bit wr, input bit sw);
        logic [31:0] exp_addr;
        logic [15:0] exp_rem;
        logic [15:0] chunk;
        int          beats;
        int          gbeat;
        int          wait_cnt;
        bit          first_cmd;
        logic [15:0] pat;
        logic [15:0] exp_d;
        exp_addr = lo | hi_addr;
        exp_rem  = len;
        if (sw) begin
            exp_addr[0] = 1'b0;
            exp_rem[0]  = 1'b0;
        end
        gbeat = 0;
        first_cmd = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R9", "ready before request", 32'(req_ready), 1);
        req_valid = 1'b1; req_addr = lo; req_len = len;
        req_to_mem = wr; req_swap = sw;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (exp_rem == 0) begin
            chk(done == 1'b1, "R10", "done after zero length", 32'(done), 1);
            chk(busy == 1'b0, "R10", "busy after zero length", 32'(busy), 0);
            chk(mem_cmd_valid == 1'b0, "R10", "no command", 32'(mem_cmd_valid), 0);
            @(negedge clk);
            chk(done == 1'b0, "R13", "done single cycle", 32'(done), 0);
            return;
        end
        chk(busy == 1'b1, "R9", "busy after accept", 32'(busy), 1);
        while (exp_rem != 0) begin
            chunk = (wr && sw && exp_rem > 16'(CHUNK)) ? 16'(CHUNK) : exp_rem;
            beats = (int'(chunk) + 1) / 2;
            wait_cnt = 0;
            while (!mem_cmd_valid && wait_cnt < 20) begin
                @(negedge clk);
                wait_cnt++;
            end
            // Stall one cycle and offer a competing request while busy.
            chk(mem_cmd_valid == 1'b1, "R12", "command appears", 32'(mem_cmd_valid), 1);
            if (first_cmd) begin
                chk(req_ready == 1'b0, "R9", "ready while busy", 32'(req_ready), 0);
                req_valid = 1'b1;
                req_addr = 32'h0000_7770; req_len = 16'd8;
            end
            @(posedge clk);
            @(negedge clk);
            req_valid = 1'b0;
            first_cmd = 1'b0;
            chk(mem_cmd_valid == 1'b1, "R12", "command held", 32'(mem_cmd_valid), 1);
            chk(mem_cmd_addr == exp_addr, sw ? "R3" : "R1", "command address",
                mem_cmd_addr, exp_addr);
            chk(mem_cmd_len == chunk, wr && sw ? "R6" : "R7", "command length",
                32'(mem_cmd_len), 32'(chunk));
            chk(mem_cmd_write == wr, "R2", "command direction",
                32'(mem_cmd_write), 32'(wr));
            mem_cmd_ready = 1'b1;
            @(posedge clk);
            @(negedge clk);
            mem_cmd_ready = 1'b0;
            for (int b = 0; b < beats; b++) begin
                pat = {8'(gbeat) ^ 8'hA5, 8'(gbeat) + 8'h11};
                exp_d = sw ? bswap(pat) : pat;
                if (wr) begin
                    per_wvalid = 1'b1; per_wdata = pat; mem_wready = 1'b1;
                    #1;
                    chk(mem_wvalid == 1'b1, "R8", "write beat valid", 32'(mem_wvalid), 1);
                    chk(mem_wdata == exp_d, sw ? "R4" : "R2", "write data",
                        32'(mem_wdata), 32'(exp_d));
                    chk(mem_wlast == (b == beats - 1), "R8", "wlast",
                        32'(mem_wlast), 32'(b == beats - 1));
                end else begin
                    mem_rvalid = 1'b1; mem_rdata = pat; per_rready = 1'b1;
                    #1;
                    chk(per_rvalid == 1'b1, "R8", "read beat valid", 32'(per_rvalid), 1);
                    chk(per_rdata == exp_d, sw ? "R5" : "R2", "read data",
                        32'(per_rdata), 32'(exp_d));
                end
                @(posedge clk);
                @(negedge clk);
                per_wvalid = 1'b0; mem_wready = 1'b0;
                mem_rvalid = 1'b0; per_rready = 1'b0;
                gbeat++;
            end
            exp_rem  = exp_rem - chunk;
            exp_addr = exp_addr + 32'(chunk);
            if (exp_rem != 0) begin
                chk(busy == 1'b1, "R9", "busy between chunks", 32'(busy), 1);
                chk(done == 1'b0, "R13", "no early done", 32'(done), 0);
            end
        end
        chk(done == 1'b1, "R13", "done after last beat", 32'(done), 1);
        chk(busy == 1'b0, "R13", "busy low at done", 32'(busy), 0);
        @(negedge clk);
        chk(done == 1'b0, "R13", "done single cycle", 32'(done), 0);
        @(negedge clk);
        chk(mem_cmd_valid == 1'b0 && busy == 1'b0, "R9",
            "refused request left no work", 32'(mem_cmd_valid), 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(busy == 1'b0, "R11", "busy at reset", 32'(busy), 0);
        chk(done == 1'b0, "R11", "done at reset", 32'(done), 0);
        chk(mem_cmd_valid == 1'b0, "R11", "cmd_valid at reset", 32'(mem_cmd_valid), 0);
        chk(mem_wvalid == 1'b0, "R11", "wvalid at reset", 32'(mem_wvalid), 0);
        chk(req_ready == 1'b1, "R11", "ready at reset", 32'(req_ready), 1);
    endtask

    task automatic t_pass_read();     // R1 R2 R7: odd address kept, no swap
        hi_addr = 32'h00FF_0000;
        run_xfer(32'h0000_1235, 16'd6, 1'b0, 1'b0);
    endtask

    task automatic t_or_overlap();    // R1: overlapping bits OR together
        hi_addr = 32'h0F00_0011;
        run_xfer(32'h00F0_0010, 16'd2, 1'b0, 1'b0);
    endtask

    task automatic t_pass_write_odd(); // R2 R8: odd length, 3 beats, one command
        hi_addr = 32'h0001_0000;
        run_xfer(32'h0000_0041, 16'd5, 1'b1, 1'b0);
    endtask

    task automatic t_pass_write_long(); // R2: long pass-through write not chunked
        hi_addr = 32'h0002_0000;
        run_xfer(32'h0000_0100, 16'd100, 1'b1, 1'b0);
    endtask

    task automatic t_swap_read();     // R3 R5 R7: aligned, swapped, single command
        hi_addr = 32'h0030_0000;
        run_xfer(32'h0000_0101, 16'd151, 1'b0, 1'b1);
    endtask

    task automatic t_swap_write();    // R3 R4 R6: chunks of 64, 64, 22
        hi_addr = 32'h0040_0000;
        run_xfer(32'h0000_0203, 16'd150, 1'b1, 1'b1);
    endtask

    task automatic t_swap_write_exact(); // R6: exact multiple of the chunk size
        hi_addr = 32'h0050_0000;
        run_xfer(32'h0000_0000, 16'd128, 1'b1, 1'b1);
    endtask

    task automatic t_zero_len();      // R10: zero and swap-aligned-to-zero
        run_xfer(32'h0000_0010, 16'd0, 1'b1, 1'b0);
        run_xfer(32'h0000_0011, 16'd1, 1'b1, 1'b1);
        run_xfer(32'h0000_0013, 16'd1, 1'b0, 1'b1);
    endtask

    // Watchdog: ends a hung run as a failure.
    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_pass_read();
        t_or_overlap();
        t_pass_write_odd();
        t_pass_write_long();
        t_swap_read();
        t_swap_write();
        t_swap_write_exact();
        t_zero_len();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule